// File: doc/BRIEF.md
# Dual-Overflow Watchdog Timer

This block is a memory-mapped watchdog. Software programs a 12-bit timeout in the upper bits of a setting register, clears the elapsed count, and then sets an enable bit. An oscillator tick, given to the block as a single-cycle enable `oscTick` in the bus clock domain, advances a counter. One overflow period lasts (value + 1) × 2^PRESCALE_LOG2 ticks. The first period that ends without a service write raises `irq`. If a second period ends back to back without a service write, the block raises `wdtReset` and holds it.

Software services the watchdog by writing 1 to bit 0 of the service register. This write acts at once: it restarts the count and clears `irq`. Every other register write passes through a modelled synchronisation stage into the oscillator domain, and `busy` reports that stage. A second path lets software force a reset on purpose by arming a fault-injection enable while the fault-policy register holds 0. Once the timer runs, its period is fixed until the block reset is applied.

Top module: `wdt_dual_overflow`

## Requirements
- R1: After the synchronous active-high `rst`, every register reads 0 and `irq`, `wdtReset` and `busy` are low.
- R2: The setting register at byte offset 0x04 stores write bits 31:20 as the timeout value. Its bits 19:0 always read 0.
- R3: Once enabled, the counter advances only on cycles with `oscTick` high. An overflow happens after (value + 1) × 2^PRESCALE_LOG2 ticks counted from the enable commit.
- R4: The first overflow with no service since the last one sets `irq`, which also reads back as bit 0 at offset 0x0C. A second consecutive unserviced overflow asserts `wdtReset`.
- R5: A write with bit 0 set to offset 0x0C is not delayed. On the next cycle the elapsed count (offset 0x08) reads 0 and `irq` is low, so a full new period starts.
- R6: Any write to offset 0x08 clears the elapsed count when it commits.
- R7: A write to offsets 0x00, 0x04, 0x08, 0x10 or 0x14 commits only after at least SYNC_BUS bus cycles and SYNC_OSC oscillator ticks. With `oscTick` high on every cycle, `busy` stays high for SYNC_BUS + 1 cycles. Further writes to these offsets while `busy` is high are dropped.
- R8: Bit 0 of offset 0x00 is the enable. It cannot be cleared by software. The period is taken from the setting register at the moment the enable commits, and later setting writes do not change the running period.
- R9: A write with bit 0 set to offset 0x14 asserts `wdtReset` at its commit if offset 0x10 bit 0 holds 0. If offset 0x10 bit 0 holds 1, the write has no effect.
- R10: Once `wdtReset` is asserted, it stays asserted until `rst`, for at least 32 oscillator cycles. While it is asserted, the elapsed count is frozen.
- R11: Offsets 0x18 and 0x1C read 0. Writes to them neither raise `busy` nor change any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high block reset |
| oscTick | input | 1 | One-cycle strobe for each oscillator cycle |
| busAddr | input | 5 | Byte address of the register access |
| busWe | input | 1 | Write strobe |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Combinational read data for `busAddr` |
| busy | output | 1 | A register write is waiting to commit |
| irq | output | 1 | First unserviced overflow pending |
| wdtReset | output | 1 | Latched system reset request |

## Verification
The assertions check, on every cycle, the properties that do not depend on a history of events:
- `wdtReset` never drops before `rst`.
- A service write always leaves `irq` low.
- The low bits of the setting register always read 0.
- The irq readback always matches the `irq` pin.
- Unmapped offsets always read 0.
- An accepted write always raises `busy`.

The bench scenarios show the behaviours that need a history of events:
- The exact overflow period across a sweep of timeout values.
- The two-step escalation from `irq` to reset.
- Latching of the period at enable time.
- The exact length of the commit latency when ticks are present or missing.
- That a write made while `busy` is high is dropped.
- The forced-reset policy.

// File: rtl/wdt_dual_overflow_pkg.sv
package wdt_dual_overflow_pkg;

  localparam int ADDR_W = 5;
  localparam int DATA_W = 32;

  // register index = byte offset / 4
  localparam logic [2:0] IDX_CTRL    = 3'd0;
  localparam logic [2:0] IDX_SET     = 3'd1;
  localparam logic [2:0] IDX_ELAPSED = 3'd2;
  localparam logic [2:0] IDX_SERVICE = 3'd3;
  localparam logic [2:0] IDX_PECTL   = 3'd4;
  localparam logic [2:0] IDX_PEEN    = 3'd5;

  // strobes from control to datapath
  typedef struct packed {
    logic commitCtrl;
    logic commitSet;
    logic commitElapsed;
    logic commitPeCtl;
    logic commitPeEn;
    logic service;
  } wdtStrobe_t;

endpackage

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_dual_overflow_pkg::*;
#(
  parameter int SYNC_BUS = 9,
  parameter int SYNC_OSC = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              oscTick,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              overflow,
  input  logic              forceReset,
  output wdtStrobe_t        strobe,
  output logic [DATA_W-1:0] commitData,
  output logic              busy,
  output logic              irq,
  output logic              wdtReset
);

  localparam int BCW = $clog2(SYNC_BUS + 1);
  localparam int OCW = $clog2(SYNC_OSC + 1);
  localparam logic [BCW-1:0] BUS_LAST = BCW'(SYNC_BUS);
  localparam logic [OCW-1:0] OSC_LAST = OCW'(SYNC_OSC);

  logic [2:0]     reqIdx;
  logic           reqMapped;
  logic           reqService;
  logic           accept;
  logic           commitNow;
  logic [2:0]     pendIdx;
  logic [BCW-1:0] busCnt;
  logic [OCW-1:0] oscCnt;

  assign reqIdx     = busAddr[4:2];
  assign reqMapped  = (reqIdx <= IDX_PEEN);
  assign reqService = (reqIdx == IDX_SERVICE);
  assign accept     = busWe && !busy && reqMapped && !reqService;
  assign commitNow  = busy && (busCnt == BUS_LAST) && (oscCnt == OSC_LAST);

  // synchronisation stage for every write except the service write
  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b0;
      pendIdx    <= '0;
      commitData <= '0;
      busCnt     <= '0;
      oscCnt     <= '0;
    end else if (accept) begin
      busy       <= 1'b1;
      pendIdx    <= reqIdx;
      commitData <= busWdata;
      busCnt     <= '0;
      oscCnt     <= '0;
    end else if (busy) begin
      if (commitNow) begin
        busy <= 1'b0;
      end else begin
        if (busCnt != BUS_LAST) busCnt <= busCnt + 1'b1;
        if (oscTick && (oscCnt != OSC_LAST)) oscCnt <= oscCnt + 1'b1;
      end
    end
  end

  always_comb begin
    strobe               = '0;
    strobe.commitCtrl    = commitNow && (pendIdx == IDX_CTRL);
    strobe.commitSet     = commitNow && (pendIdx == IDX_SET);
    strobe.commitElapsed = commitNow && (pendIdx == IDX_ELAPSED);
    strobe.commitPeCtl   = commitNow && (pendIdx == IDX_PECTL);
    strobe.commitPeEn    = commitNow && (pendIdx == IDX_PEEN);
    strobe.service       = busWe && reqService && busWdata[0];
  end

  // overflow tracking: first overflow flags, second one resets
  always_ff @(posedge clk) begin
    if (rst) begin
      irq <= 1'b0;
    end else if (strobe.service) begin
      irq <= 1'b0;
    end else if (overflow) begin
      irq <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wdtReset <= 1'b0;
    end else if (forceReset || (overflow && irq && !strobe.service)) begin
      wdtReset <= 1'b1;
    end
  end

endmodule

// File: rtl/wdt_datapath.sv
module wdt_datapath
  import wdt_dual_overflow_pkg::*;
#(
  parameter int TIMEOUT_W     = 12,
  parameter int PRESCALE_LOG2 = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              oscTick,
  input  wdtStrobe_t        strobe,
  input  logic [DATA_W-1:0] commitData,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              irq,
  input  logic              resetOut,
  output logic              overflow,
  output logic              forceReset,
  output logic [DATA_W-1:0] busRdata
);

  localparam int CW      = TIMEOUT_W + PRESCALE_LOG2;
  localparam int SET_LSB = DATA_W - TIMEOUT_W;
  localparam logic [PRESCALE_LOG2-1:0] PRE_ONES = '1;

  logic                 enabled;
  logic [TIMEOUT_W-1:0] setVal;
  logic [TIMEOUT_W-1:0] periodVal;
  logic                 peCtl;
  logic [CW-1:0]        elapsed;
  logic [CW-1:0]        limit;
  logic                 atLimit;
  logic                 advance;

  // last count of a period: (v+1)*2^P - 1
  assign limit   = {periodVal, PRE_ONES};
  assign atLimit = (elapsed == limit);
  assign advance = enabled && oscTick && !resetOut;

  assign overflow   = advance && atLimit && !strobe.service;
  assign forceReset = strobe.commitPeEn && commitData[0] && !peCtl;

  always_ff @(posedge clk) begin
    if (rst) begin
      enabled   <= 1'b0;
      periodVal <= '0;
    end else if (strobe.commitCtrl && commitData[0] && !enabled) begin
      enabled   <= 1'b1;
      periodVal <= setVal;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      setVal <= '0;
    end else if (strobe.commitSet) begin
      setVal <= commitData[DATA_W-1:SET_LSB];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      peCtl <= 1'b0;
    end else if (strobe.commitPeCtl) begin
      peCtl <= commitData[0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      elapsed <= '0;
    end else if (strobe.service || strobe.commitElapsed) begin
      elapsed <= '0;
    end else if (advance) begin
      elapsed <= atLimit ? '0 : elapsed + 1'b1;
    end
  end

  always_comb begin
    busRdata = '0;
    unique case (busAddr[4:2])
      IDX_CTRL:    busRdata[0] = enabled;
      IDX_SET:     busRdata = {setVal, {SET_LSB{1'b0}}};
      IDX_ELAPSED: busRdata = 32'(elapsed);
      IDX_SERVICE: busRdata[0] = irq;
      IDX_PECTL:   busRdata[0] = peCtl;
      default:     busRdata = '0;
    endcase
  end

endmodule

// File: rtl/wdt_dual_overflow.sv
module wdt_dual_overflow
  import wdt_dual_overflow_pkg::*;
#(
  parameter int TIMEOUT_W     = 12,
  parameter int PRESCALE_LOG2 = 20,
  parameter int SYNC_BUS      = 9,
  parameter int SYNC_OSC      = 6
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        oscTick,
  input  logic [4:0]  busAddr,
  input  logic        busWe,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata,
  output logic        busy,
  output logic        irq,
  output logic        wdtReset
);

  wdtStrobe_t        strobe;
  logic [DATA_W-1:0] commitData;
  logic              overflow;
  logic              forceReset;

  wdt_ctrl #(
    .SYNC_BUS(SYNC_BUS),
    .SYNC_OSC(SYNC_OSC)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .oscTick   (oscTick),
    .busAddr   (busAddr),
    .busWe     (busWe),
    .busWdata  (busWdata),
    .overflow  (overflow),
    .forceReset(forceReset),
    .strobe    (strobe),
    .commitData(commitData),
    .busy      (busy),
    .irq       (irq),
    .wdtReset  (wdtReset)
  );

  wdt_datapath #(
    .TIMEOUT_W    (TIMEOUT_W),
    .PRESCALE_LOG2(PRESCALE_LOG2)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .oscTick   (oscTick),
    .strobe    (strobe),
    .commitData(commitData),
    .busAddr   (busAddr),
    .irq       (irq),
    .resetOut  (wdtReset),
    .overflow  (overflow),
    .forceReset(forceReset),
    .busRdata  (busRdata)
  );

endmodule

// File: rtl/wdt_dual_overflow_chk.sv
module wdt_dual_overflow_chk (
  input logic        clk,
  input logic        rst,
  input logic [4:0]  busAddr,
  input logic        busWe,
  input logic [31:0] busWdata,
  input logic [31:0] busRdata,
  input logic        busy,
  input logic        irq,
  input logic        wdtReset
);

  logic syncWrite;
  assign syncWrite = busWe && (busAddr[4:2] <= 3'd5) && (busAddr[4:2] != 3'd3);

  AST_RESET_HELD: assert property (@(posedge clk) disable iff (rst)
    wdtReset |=> wdtReset); // R10

  AST_SERVICE_CLEARS_IRQ: assert property (@(posedge clk) disable iff (rst)
    (busWe && busAddr[4:2] == 3'd3 && busWdata[0]) |=> !irq); // R5

  AST_SET_LOW_ZERO: assert property (@(posedge clk) disable iff (rst)
    (busAddr[4:2] == 3'd1) |-> (busRdata[19:0] == 20'd0)); // R2

  AST_IRQ_READBACK: assert property (@(posedge clk) disable iff (rst)
    (busAddr[4:2] == 3'd3) |-> (busRdata[0] == irq)); // R4

  AST_WRITE_STARTS_SYNC: assert property (@(posedge clk) disable iff (rst)
    (!busy && syncWrite) |=> busy); // R7

  AST_UNMAPPED_QUIET: assert property (@(posedge clk) disable iff (rst)
    (busAddr[4:2] > 3'd5) |-> (busRdata == 32'd0)); // R11

endmodule

bind wdt_dual_overflow wdt_dual_overflow_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .busAddr (busAddr),
  .busWe   (busWe),
  .busWdata(busWdata),
  .busRdata(busRdata),
  .busy    (busy),
  .irq     (irq),
  .wdtReset(wdtReset)
);

// File: tb/wdt_dual_overflow_bench.sv
`timescale 1ns/1ps
module wdt_dual_overflow_bench;

  localparam int P    = 2;
  localparam int SB   = 9;
  localparam int SO   = 6;
  localparam int PRE  = 1 << P;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        oscTick = 1'b1;
  logic [4:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        busy, irq, wdtReset;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  wdt_dual_overflow #(
    .TIMEOUT_W(12), .PRESCALE_LOG2(P), .SYNC_BUS(SB), .SYNC_OSC(SO)
  ) u_wdt_dual_overflow (
    .clk(clk), .rst(rst), .oscTick(oscTick), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .busy(busy), .irq(irq),
    .wdtReset(wdtReset)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic resetDut();
    @(negedge clk); rst = 1'b1; busWe = 1'b0; oscTick = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk); busWe = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    busAddr = a; #1; d = busRdata;
  endtask

  task automatic waitIdle(output int c);
    c = 0;
    while (busy && c < 100000) begin @(negedge clk); c++; end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic untilIrq(output int c);
    c = 0;
    while (!irq && c < 100000) begin @(negedge clk); c++; end
  endtask

  task automatic untilRst(output int c);
    c = 0;
    while (!wdtReset && c < 100000) begin @(negedge clk); c++; end
  endtask

  initial begin : watchdog
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] d, e;
    int c;
    resetDut();

    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      rd(5'(a * 4), d);
      chk(d == 0, "R1 reg after reset", d, 0);
    end
    chk(!irq && !wdtReset && !busy, "R1 outputs after reset",
        {irq, wdtReset, busy}, 0);

    // R2 setting field
    wr(5'h04, 32'hABCD_EF12); waitIdle(c);
    chk(c == SB + 1, "R7 busy length", c, SB + 1);
    rd(5'h04, d);
    chk(d == 32'hABC0_0000, "R2 setting readback", d, 32'hABC0_0000);

    // R7 write dropped while busy
    wr(5'h04, 32'h1110_0000);
    wr(5'h04, 32'h2220_0000);
    waitIdle(c);
    rd(5'h04, d);
    chk(d == 32'h1110_0000, "R7 write while busy dropped", d, 32'h1110_0000);

    // R7 commit waits for oscillator ticks
    @(negedge clk); oscTick = 1'b0;
    wr(5'h10, 32'h1);
    idle(20);
    chk(busy == 1'b1, "R7 busy held without ticks", busy, 1);
    oscTick = 1'b1;
    waitIdle(c);
    chk(c == SO + 1, "R7 commit after osc ticks", c, SO + 1);

    // R11 unmapped offsets
    wr(5'h18, 32'hFFFF_FFFF);
    chk(busy == 1'b0, "R11 unmapped write no busy", busy, 0);
    rd(5'h18, d);
    chk(d == 0, "R11 unmapped read", d, 0);
    rd(5'h1C, d);
    chk(d == 0, "R11 unmapped read 1C", d, 0);

    // R3 R4 R10 sweep of timeout values
    for (int v = 0; v < 6; v++) begin
      resetDut();
      wr(5'h04, 32'(v) << 20); waitIdle(c);
      wr(5'h00, 32'h1); waitIdle(c);
      untilIrq(c);
      chk(c == PRE * (v + 1), "R3 period to irq", c, PRE * (v + 1));
      rd(5'h0C, d);
      chk(d == 1, "R4 irq readback", d, 1);
      chk(wdtReset == 0, "R4 no reset after first overflow", wdtReset, 0);
      untilRst(c);
      chk(c == PRE * (v + 1), "R4 reset after second overflow", c, PRE * (v + 1));
      rd(5'h08, d); idle(10); rd(5'h08, e);
      chk(d == e, "R10 count frozen", e, d);
      idle(40);
      chk(wdtReset == 1, "R10 reset held", wdtReset, 1);
    end
    resetDut();
    chk(wdtReset == 0 && irq == 0, "R1 rst clears latch", {irq, wdtReset}, 0);

    // R3 ticks gate counting
    wr(5'h04, 32'h0070_0000); waitIdle(c);
    wr(5'h00, 32'h1); waitIdle(c);
    @(negedge clk); oscTick = 1'b0;
    rd(5'h08, d); idle(20); rd(5'h08, e);
    chk(d == e, "R3 no count without tick", e, d);
    oscTick = 1'b1;

    // R5 service
    wr(5'h0C, 32'h1);
    rd(5'h08, d);
    chk(d == 0, "R5 service clears count", d, 0);
    for (int k = 0; k < 5; k++) begin
      idle(20);
      wr(5'h0C, 32'h1);
    end
    chk(!irq && !wdtReset, "R5 serviced no irq", {irq, wdtReset}, 0);
    untilIrq(c);
    chk(c == PRE * 8, "R5 full period after service", c, PRE * 8);
    wr(5'h0C, 32'h1);
    chk(irq == 0, "R5 service clears irq", irq, 0);
    untilRst(c);
    chk(c == 2 * PRE * 8, "R5 reset two periods after service", c, 2 * PRE * 8);

    // R8 period latched, enable sticky; R6 elapsed clear
    resetDut();
    wr(5'h04, 32'h0070_0000); waitIdle(c);
    wr(5'h00, 32'h1); waitIdle(c);
    wr(5'h04, 32'h0000_0000); waitIdle(c);
    wr(5'h00, 32'h0); waitIdle(c);
    rd(5'h00, d);
    chk(d == 1, "R8 enable sticky", d, 1);
    rd(5'h04, d);
    chk(d == 0, "R8 setting readback updated", d, 0);
    wr(5'h08, 32'h0); waitIdle(c);
    rd(5'h08, d);
    chk(d == 0, "R6 elapsed write clears", d, 0);
    wr(5'h0C, 32'h1);
    untilIrq(c);
    chk(c == PRE * 8, "R8 period unchanged", c, PRE * 8);

    // R9 forced reset policy
    resetDut();
    wr(5'h10, 32'h1); waitIdle(c);
    wr(5'h14, 32'h1); waitIdle(c);
    idle(5);
    chk(wdtReset == 0, "R9 blocked when policy 1", wdtReset, 0);
    rd(5'h10, d);
    chk(d == 1, "R9 policy readback", d, 1);
    wr(5'h10, 32'h0); waitIdle(c);
    wr(5'h14, 32'h1); waitIdle(c);
    chk(wdtReset == 1, "R9 forced reset", wdtReset, 1);
    idle(40);
    chk(wdtReset == 1, "R10 forced reset held", wdtReset, 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule